// File: doc/BRIEF.md
# Status Channel Calendar Framer

This block drives the transmit side of a packet interface's flow-control status channel. On every enabled clock it puts out one 2-bit status word. A full cycle is built in a fixed order. It starts with a framing word. An optional calendar-select word may follow. Then come several passes over a calendar of port slots, and the cycle ends with an inverted diagonal parity word.

Each slot names a port through a per-slot table. Two such tables exist, one per calendar. The status word sent for a slot is that port's current 2-bit flow-control value.

Slot count and pass count are programmed one below their real values. The block samples all configuration only while the framing word is on the line, so a calendar already in progress always completes under the settings it started with. In LVDS signalling mode the block rounds the programmed length up to the next value of the form 4n-1.

Top module: `stat_cal_framer`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `stat_o` is 2'b11 and `stat_vld_o` is 0.
- R2: With `enable` high, each cycle is sent in this order: one framing word 2'b11, an optional select word, the data words, and one parity word. The next framing word follows the parity word directly.
- R3: One calendar pass holds `cfg_len`+1 data words.
- R4: The calendar is sent `cfg_rep`+1 times between the select word (or the framing word) and the parity word.
- R5: The block keeps an accumulator. It is set to 2'b11 at the framing word. For each later select or data word w, it becomes {acc[0],acc[1]} ^ w. The parity word sent is ~acc.
- R6: A port status of 2'b11 is sent as 2'b10, so data words never equal 2'b11.
- R7: Data word s of a pass is `port_status[2p+1:2p]`, where p = `map0`/`map1`[s*PORT_W +: PORT_W] of the active calendar.
- R8: If `sw_en` is high at the framing word, a select word follows it: 2'b01 picks calendar 0 and 2'b10 picks calendar 1, as chosen by `cal_sel`. If `sw_en` is low, no select word is sent and calendar 0 is used.
- R9: If `lvds_mode` is high at the framing word, the length in use is `cfg_len` with its two low bits forced to 1. For example, a programmed 1 gives 4 slots.
- R10: `cfg_len`, `cfg_rep`, `sw_en`, `cal_sel` and `lvds_mode` are sampled only during the framing word. A change made during a calendar first affects the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sequencer; low forces idle framing |
| lvds_mode | input | 1 | 1: LVDS length rounding, 0: any length |
| sw_en | input | 1 | Enables the calendar-select word |
| cal_sel | input | 1 | Calendar for the next cycle (0 or 1) |
| cfg_len | input | LEN_W | Slots per pass minus one |
| cfg_rep | input | REP_W | Passes per cycle minus one |
| map0 | input | MAX_SLOTS*PORT_W | Slot-to-port table, calendar 0 |
| map1 | input | MAX_SLOTS*PORT_W | Slot-to-port table, calendar 1 |
| port_status | input | 2*NUM_PORTS | Per-port 2-bit status values |
| stat_o | output | 2 | Status word |
| stat_vld_o | output | 1 | Status word valid |

## Verification
The assertions assume that the slot tables and port status stay steady within a word. They also assume that every table entry names a port that exists, which always holds when NUM_PORTS is a power of two. They do not check that the calendar length covers every active port, because that is the programmer's duty. The stimulus uses eight ports and keeps the tables fixed. It changes only configuration inputs between cycles, apart from one deliberate change in the middle of a calendar. It also drops `enable` at chosen points to exercise the idle behaviour.

// File: rtl/stat_cal_framer.sv
module stat_cal_framer #(
  parameter int NUM_PORTS = 8,
  parameter int MAX_SLOTS = 256,
  parameter int REP_W     = 8,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int LEN_W    = $clog2(MAX_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        lvds_mode,
  input  logic                        sw_en,
  input  logic                        cal_sel,
  input  logic [LEN_W-1:0]            cfg_len,
  input  logic [REP_W-1:0]            cfg_rep,
  input  logic [MAX_SLOTS*PORT_W-1:0] map0,
  input  logic [MAX_SLOTS*PORT_W-1:0] map1,
  input  logic [2*NUM_PORTS-1:0]      port_status,
  output logic [1:0]                  stat_o,
  output logic                        stat_vld_o
);

  typedef enum logic [1:0] {S_FRAME, S_SEL, S_DATA, S_PAR} st_t;

  st_t              st;
  logic [LEN_W-1:0] len_l, slot;
  logic [REP_W-1:0] rep_l, rep;
  logic             cal_l;
  logic [1:0]       acc, word;

  wire [PORT_W-1:0] port_idx = cal_l ? map1[slot*PORT_W +: PORT_W]
                                     : map0[slot*PORT_W +: PORT_W];
  wire [1:0] raw    = port_status[{port_idx, 1'b0} +: 2];
  wire [1:0] data_w = (raw == 2'b11) ? 2'b10 : raw;
  wire       live   = enable && rst_n;

  always_comb begin
    case (st)
      S_SEL:   word = cal_l ? 2'b10 : 2'b01;
      S_DATA:  word = data_w;
      S_PAR:   word = ~acc;
      default: word = 2'b11;
    endcase
  end

  assign stat_o     = live ? word : 2'b11;
  assign stat_vld_o = live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_FRAME;
      len_l <= LEN_W'(1);
      rep_l <= REP_W'(7);
      cal_l <= 1'b0;
      slot  <= '0;
      rep   <= '0;
      acc   <= 2'b11;
    end else if (!enable) begin
      st <= S_FRAME;
    end else begin
      case (st)
        S_FRAME: begin
          len_l <= cfg_len | {{(LEN_W-2){1'b0}}, {2{lvds_mode}}};
          rep_l <= cfg_rep;
          cal_l <= sw_en & cal_sel;
          slot  <= '0;
          rep   <= '0;
          acc   <= 2'b11;
          st    <= sw_en ? S_SEL : S_DATA;
        end
        S_SEL: begin
          acc <= {acc[0], acc[1]} ^ word;
          st  <= S_DATA;
        end
        S_DATA: begin
          acc <= {acc[0], acc[1]} ^ word;
          if (slot == len_l) begin
            slot <= '0;
            if (rep == rep_l) st <= S_PAR;
            else              rep <= rep + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        default: st <= S_FRAME;
      endcase
    end
  end

  assert_idle_frame_R1: assert property (@(posedge clk)
    !enable |=> (st == S_FRAME));
  assert_par_then_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == S_PAR) |=> (!enable || stat_o == 2'b11));
  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= len_l);
  assert_rep_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rep <= rep_l);
  assert_no_frame_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && st == S_DATA) |-> (stat_o != 2'b11));
  assert_sel_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == S_FRAME && sw_en) |=> (!enable || st == S_SEL));
  assert_lvds_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == S_FRAME && lvds_mode) |=> (len_l[1:0] == 2'b11));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_FRAME) |=> ($stable(len_l) && $stable(rep_l) && $stable(cal_l)));

endmodule

// File: tb/stat_cal_framer_tb_top.sv
module stat_cal_framer_tb_top;
  localparam int NP = 8, MS = 256, RW = 8, PW = 3, LW = 8;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, lvds_mode = 1'b0, sw_en = 1'b0, cal_sel = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [RW-1:0] cfg_rep = '0;
  logic [MS*PW-1:0] map0, map1;
  logic [2*NP-1:0] port_status;
  logic [1:0] stat_o;
  logic stat_vld_o;
  int n_chk = 0, n_pass = 0;

  always #4 clk = ~clk;

  stat_cal_framer #(.NUM_PORTS(NP), .MAX_SLOTS(MS), .REP_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lvds_mode(lvds_mode), .sw_en(sw_en),
    .cal_sel(cal_sel), .cfg_len(cfg_len), .cfg_rep(cfg_rep), .map0(map0), .map1(map1),
    .port_status(port_status), .stat_o(stat_o), .stat_vld_o(stat_vld_o));

  // {len, rep, lvds, sw, sel, total words including framing and parity}
  localparam int VEC [5][6] = '{
    '{1, 7, 0, 0, 0, 18},
    '{2, 0, 0, 1, 1, 6},
    '{1, 1, 1, 0, 0, 10},
    '{4, 2, 1, 1, 0, 27},
    '{0, 0, 0, 0, 0, 3}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_cal(input int len, rep, lvds, sw, sel, total,
                         input bit restart, input int chg_len, input int stop_at);
    int eff, cal, cnt;
    logic [1:0] acc, exp_w;
    if (restart) begin
      @(negedge clk); enable = 1'b0;
    end
    cfg_len = LW'(len); cfg_rep = RW'(rep); lvds_mode = lvds[0]; sw_en = sw[0]; cal_sel = sel[0];
    if (restart) begin
      @(negedge clk); enable = 1'b1;
    end
    #1;
    eff = lvds ? (len | 3) : len;
    cal = sw ? sel : 0;
    acc = 2'b11;
    cnt = 1;
    check(stat_o == 2'b11 && stat_vld_o, "R2 framing word", stat_o, 3);
    step();
    if (sw) begin
      exp_w = sel ? 2'b10 : 2'b01;
      check(stat_o == exp_w, "R8 select word", stat_o, exp_w);
      acc = {acc[0], acc[1]} ^ stat_o;
      cnt++;
      step();
    end
    for (int r = 0; r <= rep; r++) begin
      for (int s = 0; s <= eff; s++) begin
        int p;
        p = cal ? 7 - (s % 8) : s % 8;
        exp_w = ((p % 4) == 3) ? 2'b10 : 2'((p % 4));
        check(stat_o == exp_w && stat_vld_o, "R7/R6 data word", stat_o, exp_w);
        acc = {acc[0], acc[1]} ^ exp_w;
        cnt++;
        if (cnt == stop_at) begin
          @(negedge clk); enable = 1'b0; #1;
          check(stat_o == 2'b11 && !stat_vld_o, "R1 disabled mid calendar", stat_o, 3);
          return;
        end
        if (chg_len >= 0 && r == 0 && s == 0) cfg_len = LW'(chg_len);
        step();
      end
    end
    check(stat_o == ~acc, "R5 parity word", stat_o, ~acc);
    cnt++;
    check(cnt == total, "R3/R4/R9 cycle length", cnt, total);
    step();
    check(stat_o == 2'b11 && stat_vld_o, "R2 framing after parity", stat_o, 3);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < MS; i++) begin
      map0[i*PW +: PW] = PW'(i % 8);
      map1[i*PW +: PW] = PW'(7 - (i % 8));
    end
    for (int p = 0; p < NP; p++) port_status[2*p +: 2] = 2'(p % 4);
    repeat (3) @(negedge clk);
    #1;
    check(stat_o == 2'b11 && !stat_vld_o, "R1 reset output", stat_o, 3);
    @(negedge clk); rst_n = 1'b1;
    // table walk over configurations
    for (int v = 0; v < 5; v++)
      run_cal(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], 1'b1, -1, -1);
    // R10: length changed mid-calendar applies only after the framing word
    run_cal(1, 0, 0, 0, 0, 4, 1'b1, 5, -1);
    run_cal(5, 0, 0, 0, 0, 8, 1'b0, -1, -1);
    // R9: lvds rounding of length 2 to 3, cal 1 selected
    run_cal(2, 0, 1, 1, 1, 7, 1'b1, -1, -1);
    // R1: disable in the middle of a calendar
    run_cal(3, 2, 0, 0, 0, 0, 1'b1, -1, 5);
    step();
    check(stat_o == 2'b11 && !stat_vld_o, "R1 stays idle", stat_o, 3);
    // R1: reset while enabled
    run_cal(1, 0, 0, 0, 0, 4, 1'b1, -1, -1);
    @(negedge clk); rst_n = 1'b0; #1;
    check(stat_o == 2'b11 && !stat_vld_o, "R1 reset while enabled", stat_o, 3);
    @(negedge clk); rst_n = 1'b1;
    run_cal(0, 1, 0, 1, 0, 5, 1'b1, -1, -1);
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule